// File: doc/BRIEF.md
# Reset-Time Diagnostic Dump Capture

This block keeps a snapshot of a wide diagnostic vector, such as a processor crash dump or a record of pending alerts, taken at the instant a system reset occurs. The reset controller drives a one-cycle event pulse together with a cause code. On that pulse the block copies the dump input into word-organised storage, provided software has armed capture and the cause is not a software-triggered peripheral reset. Power-on reset is the block's own asynchronous reset, and it is the only thing that clears the storage.

Software reaches the block through a small register port. A control register holds the capture enable and a word index. A data window returns the 32-bit stored word that the index selects. A read-only attribute register reports how many words the dump occupies. A write-zero-to-clear lock bit freezes the control register. Once cleared, the lock stays cleared until the next power-on reset, and reset events never set it again.

Top module: `rstdump_capture`

## Requirements
- R1: After power-on reset the lock bit (LOCK, offset 0x0, bit 0) reads 1, the control register (CTRL, offset 0x4) reads 0, and every stored word reads 0.
- R2: On a clock edge where `rst_evt_i` is 1, `rst_cause_i` is not 0 and the CTRL enable (bit 0) is 1, the storage takes the `dump_i` value present at that edge. Later changes of `dump_i` do not alter it.
- R3: While the CTRL enable is 0, a reset event leaves the stored words unchanged.
- R4: A reset event with cause code 0 (software peripheral reset) never changes the stored words, whatever the enable.
- R5: Reading INFO (offset 0xC) returns stored word k, where k is the CTRL index field (bits 11:8). Word 0 holds dump bits 31:0, word 1 holds bits 63:32, and so on.
- R6: An index at or above the word count makes INFO read 0.
- R7: When the dump width is not a multiple of 32, the unused upper bits of the last word read 0.
- R8: ATTR (offset 0x8) reads the word count, ceil(DUMP_W/32).
- R9: Writing LOCK with bit 0 = 0 clears the lock, and writing bit 0 = 1 has no effect. While the lock is 0, writes to CTRL are ignored.
- R10: A reset event neither sets the lock again nor changes CTRL.
- R11: When a CTRL write and a reset event fall on the same edge, the capture decision uses the enable value from before that write.
- R12: A read strobe returns its data with `reg_rvalid_o` = 1 exactly one cycle later. Without a strobe, `reg_rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| dump_i | input | DUMP_W | Diagnostic vector to capture |
| rst_evt_i | input | 1 | One-cycle system reset event |
| rst_cause_i | input | 2 | Cause of the event; 0 = software peripheral reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Byte address; bits 3:2 select the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_re_i |

## Verification
A software write to the control register and a reset event can land on the same clock edge. The bench provokes this by driving both strobes in one cycle, once arming capture from the disarmed state and once disarming it from the armed state. It then reads every stored word. The first case must leave the old snapshot in place and the second must hold the dump driven in that cycle, which shows that the capture decision uses the enable as it stood before the write.

// File: rtl/rstdump_pkg.sv
package rstdump_pkg;

  typedef enum logic [1:0] {
    REG_LOCK = 2'd0,
    REG_CTRL = 2'd1,
    REG_ATTR = 2'd2,
    REG_INFO = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CAUSE_SW_PERIPH = 2'd0,
    CAUSE_LOW_POWER = 2'd1,
    CAUSE_DEBUG     = 2'd2,
    CAUSE_HW_REQ    = 2'd3
  } cause_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_IDX_LSB = 8;
  localparam int unsigned REG_W        = 32;

endpackage

// File: rtl/rstdump_ctrl_regs.sv
module rstdump_ctrl_regs
  import rstdump_pkg::*;
#(
  parameter int unsigned IDX_FW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              lock_o,
  output logic              en_o,
  output logic [IDX_FW-1:0] idx_o
);

  logic              lock_q;
  logic              en_q, en_d;
  logic [IDX_FW-1:0] idx_q, idx_d;
  logic              lock_clr;
  logic              ctrl_upd;

  // clock enables
  assign lock_clr = we_i && (sel_i == REG_LOCK) && !wdata_i[0];
  assign ctrl_upd = we_i && (sel_i == REG_CTRL) && lock_q;

  always_comb begin
    en_d  = wdata_i[CTRL_EN_BIT];
    idx_d = wdata_i[CTRL_IDX_LSB +: IDX_FW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_clr) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else if (ctrl_upd) begin
      en_q  <= en_d;
      idx_q <= idx_d;
    end
  end

  assign lock_o = lock_q;
  assign en_o   = en_q;
  assign idx_o  = idx_q;

  // R10: once cleared the lock stays cleared
  p_lock_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);

  // R9: a locked control register holds its contents
  p_ctrl_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> ($stable(en_q) && $stable(idx_q)));

  // R9: writing a one to the lock bit does not clear it
  p_lock_w1_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i && (sel_i == REG_LOCK) && wdata_i[0]) |=> lock_q);

endmodule

// File: rtl/rstdump_store.sv
module rstdump_store
  import rstdump_pkg::*;
#(
  parameter int unsigned DUMP_W = 100,
  parameter int unsigned WORDS  = (DUMP_W + 31) / 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        evt_i,
  input  logic [1:0]                  cause_i,
  input  logic                        en_i,
  input  logic [DUMP_W-1:0]           dump_i,
  output logic [WORDS-1:0][REG_W-1:0] words_o
);

  localparam int unsigned FLAT_W = WORDS * REG_W;
  localparam int unsigned PAD_W  = FLAT_W - DUMP_W;

  logic [FLAT_W-1:0] padded;
  logic              cap;

  generate
    if (PAD_W > 0) begin : g_pad
      assign padded = {{PAD_W{1'b0}}, dump_i};
    end else begin : g_nopad
      assign padded = dump_i;
    end
  endgenerate

  // capture only for system causes with capture armed
  assign cap = evt_i && en_i && (cause_i != CAUSE_SW_PERIPH);

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [REG_W-1:0] word_q, word_d;

      always_comb begin
        word_d = padded[g*REG_W +: REG_W];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          word_q <= '0;
        end else if (cap) begin
          word_q <= word_d;
        end
      end

      assign words_o[g] = word_q;
    end
  endgenerate

  // R2: armed system event stores the dump present at that edge
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && en_i && (cause_i != CAUSE_SW_PERIPH)) |=> (words_o == $past(padded)));

  // R3: disarmed capture holds the storage
  p_disabled_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(words_o));

  // R4: software peripheral reset never disturbs the storage
  p_sw_reset_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && (cause_i == CAUSE_SW_PERIPH)) |=> $stable(words_o));

  generate
    if (PAD_W > 0) begin : g_pad_chk
      // R7: padding of the last word stays zero
      p_pad_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        words_o[WORDS-1][REG_W-1 -: PAD_W] == '0);
    end
  endgenerate

endmodule

// File: rtl/rstdump_readmux.sv
module rstdump_readmux
  import rstdump_pkg::*;
#(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned IDX_FW = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        re_i,
  input  logic [1:0]                  sel_i,
  input  logic                        lock_i,
  input  logic                        en_i,
  input  logic [IDX_FW-1:0]           idx_i,
  input  logic [WORDS-1:0][REG_W-1:0] words_i,
  output logic [REG_W-1:0]            rdata_o,
  output logic                        rvalid_o
);

  logic [REG_W-1:0] info_word;
  logic [REG_W-1:0] ctrl_word;
  logic [REG_W-1:0] rdata_d, rdata_q;
  logic             rvalid_q;

  // out-of-range index falls through to zero
  always_comb begin
    info_word = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (32'(idx_i) == 32'(w)) begin
        info_word = words_i[w];
      end
    end
  end

  always_comb begin
    ctrl_word                               = '0;
    ctrl_word[CTRL_EN_BIT]                  = en_i;
    ctrl_word[CTRL_IDX_LSB +: IDX_FW]       = idx_i;
  end

  always_comb begin
    unique case (sel_i)
      REG_LOCK: rdata_d = {{(REG_W-1){1'b0}}, lock_i};
      REG_CTRL: rdata_d = ctrl_word;
      REG_ATTR: rdata_d = REG_W'(WORDS);
      default:  rdata_d = info_word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R12: one-cycle read latency
  p_rvalid_after_re_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o);
  p_no_rvalid_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_o);

  // R6: index beyond the dump reads zero
  p_info_oob_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (sel_i == REG_INFO) && (32'(idx_i) >= 32'(WORDS))) |=> (rdata_o == '0));

  // R8: attribute register reports the word count
  p_attr_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (sel_i == REG_ATTR)) |=> (rdata_o == 32'(WORDS)));

endmodule

// File: rtl/rstdump_capture.sv
module rstdump_capture
  import rstdump_pkg::*;
#(
  parameter int unsigned DUMP_W = 100,
  parameter int unsigned IDX_FW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUMP_W-1:0] dump_i,
  input  logic              rst_evt_i,
  input  logic [1:0]        rst_cause_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o
);

  localparam int unsigned WORDS = (DUMP_W + REG_W - 1) / REG_W;

  logic [1:0]                  sel;
  logic                        lock;
  logic                        en;
  logic [IDX_FW-1:0]           idx;
  logic [WORDS-1:0][REG_W-1:0] words;

  assign sel = reg_addr_i[3:2];

  rstdump_ctrl_regs #(
    .IDX_FW (IDX_FW)
  ) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (sel),
    .wdata_i (reg_wdata_i),
    .lock_o  (lock),
    .en_o    (en),
    .idx_o   (idx)
  );

  rstdump_store #(
    .DUMP_W (DUMP_W),
    .WORDS  (WORDS)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (rst_evt_i),
    .cause_i (rst_cause_i),
    .en_i    (en),
    .dump_i  (dump_i),
    .words_o (words)
  );

  rstdump_readmux #(
    .WORDS  (WORDS),
    .IDX_FW (IDX_FW)
  ) i_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .re_i     (reg_re_i),
    .sel_i    (sel),
    .lock_i   (lock),
    .en_i     (en),
    .idx_i    (idx),
    .words_i  (words),
    .rdata_o  (reg_rdata_o),
    .rvalid_o (reg_rvalid_o)
  );

  // R10 / R11: a reset event alone never alters the control state
  p_evt_keeps_ctrl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_evt_i && !reg_we_i) |=> ($stable(en) && $stable(idx) && $stable(lock)));

endmodule

// File: tb/test_rstdump_capture.sv
module test_rstdump_capture;

  localparam int unsigned DUMP_W = 100;
  localparam int unsigned IDX_FW = 4;
  localparam int unsigned WORDS  = (DUMP_W + 31) / 32;

  logic              clk;
  logic              rst_n;
  logic [DUMP_W-1:0] dump;
  logic              evt;
  logic [1:0]        cause;
  logic              we, re;
  logic [3:0]        addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              rvalid;

  int n_chk;
  int n_bad;
  bit finished;

  // scoreboard queues
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model
  logic [WORDS*32-1:0] m_dump;
  logic                m_lock;
  logic                m_en;
  logic [IDX_FW-1:0]   m_idx;

  rstdump_capture #(.DUMP_W(DUMP_W), .IDX_FW(IDX_FW)) i_rstdump_capture (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .dump_i       (dump),
    .rst_evt_i    (evt),
    .rst_cause_i  (cause),
    .reg_we_i     (we),
    .reg_re_i     (re),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .reg_rvalid_o (rvalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DUMP_W-1:0] rnd_dump();
    logic [127:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom()};
    return t[DUMP_W-1:0];
  endfunction

  function automatic logic [31:0] expect_for(input logic [1:0] s);
    logic [31:0] v;
    v = '0;
    case (s)
      2'd0: v[0] = m_lock;
      2'd1: begin v[0] = m_en; v[8 +: IDX_FW] = m_idx; end
      2'd2: v = 32'(WORDS);
      default: if (32'(m_idx) < WORDS) v = m_dump[32'(m_idx)*32 +: 32];
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] s, input logic [31:0] d);
    if (s == 2'd0 && !d[0]) m_lock = 1'b0;
    if (s == 2'd1 && m_lock) begin
      m_en  = d[0];
      m_idx = d[8 +: IDX_FW];
    end
  endtask

  task automatic model_event(input logic [1:0] c, input logic [DUMP_W-1:0] d);
    if (c != 2'd0 && m_en) begin
      m_dump = '0;
      m_dump[DUMP_W-1:0] = d;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    we = 1'b1; addr = {s, 2'b00}; wdata = d;
    model_write(s, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input string tag);
    re = 1'b1; addr = {s, 2'b00};
    exp_q.push_back(expect_for(s));
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic fire(input logic [1:0] c, input logic [DUMP_W-1:0] d);
    evt = 1'b1; cause = c; dump = d;
    model_event(c, d);
    @(negedge clk);
    evt = 1'b0;
    dump = rnd_dump();   // input moves on after the event
  endtask

  // R11: write and event on the same edge; capture uses the prior enable
  task automatic wr_fire(input logic [31:0] d, input logic [1:0] c, input logic [DUMP_W-1:0] dd);
    we = 1'b1; addr = 4'h4; wdata = d;
    evt = 1'b1; cause = c; dump = dd;
    model_event(c, dd);
    model_write(2'd1, d);
    @(negedge clk);
    we = 1'b0; evt = 1'b0;
    dump = rnd_dump();
  endtask

  task automatic read_all_words(input string tag);
    logic [IDX_FW-1:0] keep_idx;
    logic              keep_en;
    keep_idx = m_idx; keep_en = m_en;
    for (int w = 0; w < WORDS; w++) begin
      wr(2'd1, {20'd0, 4'(w), 7'd0, keep_en});
      rd(2'd3, tag);
    end
    wr(2'd1, {20'd0, keep_idx, 7'd0, keep_en});
  endtask

  // monitor: pops the expected item when the response appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12: actual unexpected rvalid expected none");
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DUMP_W-1:0] d;
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; evt = 1'b0; cause = 2'd0; we = 1'b0; re = 1'b0;
    addr = '0; wdata = '0; dump = rnd_dump();
    m_dump = '0; m_lock = 1'b1; m_en = 1'b0; m_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12: reset state
    check("R12 idle rvalid", {31'd0, rvalid}, 32'd0);
    rd(2'd0, "R1 lock after reset");
    rd(2'd1, "R1 ctrl after reset");
    read_all_words("R1 storage after reset");
    rd(2'd2, "R8 attr word count");

    // R2 / R5 / R7: armed capture with debug cause
    wr(2'd1, 32'h0000_0001);
    fire(2'd2, rnd_dump());
    read_all_words("R2 R5 R7 captured words");

    // R6: index beyond the dump
    wr(2'd1, {20'd0, 4'(WORDS), 8'h01});
    rd(2'd3, "R6 index at word count");
    wr(2'd1, 32'h0000_0F01);
    rd(2'd3, "R6 index maximum");

    // R4: software peripheral reset while armed
    wr(2'd1, 32'h0000_0001);
    fire(2'd0, rnd_dump());
    read_all_words("R4 sw reset keeps dump");

    // R2: all-ones pattern with hardware-request cause
    d = '1;
    fire(2'd3, d);
    read_all_words("R2 R7 ones pattern");

    // R3: disarmed
    wr(2'd1, 32'h0000_0000);
    fire(2'd1, rnd_dump());
    read_all_words("R3 disarmed keeps dump");

    // R11: arm on same edge as event -> no capture
    wr_fire(32'h0000_0001, 2'd1, rnd_dump());
    read_all_words("R11 arm same edge");
    rd(2'd1, "R11 ctrl after arm");
    // armed now: capture
    fire(2'd2, rnd_dump());
    read_all_words("R2 capture after arm");
    // R11: disarm on same edge as event -> capture
    wr_fire(32'h0000_0000, 2'd3, rnd_dump());
    read_all_words("R11 disarm same edge");

    // R9: lock handling
    wr(2'd1, 32'h0000_0001);
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, "R9 write one keeps lock");
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, "R9 write zero clears lock");
    wr(2'd1, 32'h0000_0200);
    rd(2'd1, "R9 ctrl write ignored");
    // R10: event does not reopen the lock; capture still armed
    fire(2'd1, rnd_dump());
    rd(2'd0, "R10 lock after event");
    rd(2'd1, "R10 ctrl after event");
    rd(2'd3, "R10 word0 after locked capture");
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, "R10 lock stays clear");

    repeat (3) @(negedge clk);
    check("R12 responses drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule